// File: doc/BRIEF.md
# Serial Shift-Register Output Driver

This block drives a 17-bit output vector off-chip through a two-wire clock and data link into an external chain of 8-bit serial-in, parallel-out shift registers. A request with a data word starts one transfer. The block shifts the word out most significant bit first and generates its own serial clock from the system clock. When the external chain has an output latch, the block also issues the latch strobe itself, so software only supplies the data.

Three configuration inputs control each transfer, and all three are captured when the transfer starts. The divisor code sets the serial clock period. The delay setting places each data transition a number of system clocks after the falling serial-clock edge. The mode bit chooses between plain shift registers and latched shift registers. A readback word holds the captured data in its low bits and a transfer-in-progress flag in its top bit. The configuration registers that feed these inputs sit outside the block.

Top module: `sipo_shift_out`

## Requirements
- R1: When `start` is high on a clock edge with no transfer running, the block captures `wr_data` and raises `busy` on that same edge. From that edge on, `rd_word` bits 16:0 show the captured word, bit 31 equals `busy`, and bits 30:17 read zero.
- R2: The divisor code c (0 to 3) gives a serial clock period of P = 4 << c system clocks (4, 8, 16 or 32). Each period is low for the first P/2 clocks and high for the last P/2 clocks. One transfer contains exactly 17 periods, and the first one begins on the start edge.
- R3: Bits leave most significant bit first, bit 16 in period 0 down to bit 0 in period 16. Within a period, `ser_data` moves to that period's bit D system clocks after the period begins, where D is the effective delay. Before that point it still holds the previous bit, or 0 in period 0. `ser_data` never changes while `ser_clk` stays high.
- R4: The effective delay D is the raw delay clamped into the range 1 to P/2: a raw value of 0 becomes 1, and a raw value above P/2 becomes P/2.
- R5: In mode 0 (no latch), `busy` falls right after the 17th serial-clock period, which is 17·P clocks after the start edge. `ser_latch` stays low.
- R6: In mode 1 (latched), `ser_latch` is high for exactly P clocks, starting right after the 17th period. `ser_clk` is low during that time, and `busy` falls when the strobe ends, 18·P clocks after the start edge.
- R7: A `start` during a running transfer is ignored. The serial stream, the strobe and the readback data continue unchanged.
- R8: After reset, and whenever no transfer runs, `ser_clk`, `ser_data`, `ser_latch` and `busy` are low. After reset `rd_word` is zero.
- R9: Changes to `cfg_mode`, `cfg_div` and `cfg_dly` while a transfer runs have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Transfer request, one cycle |
| wr_data | input | 17 | Word to shift out |
| cfg_mode | input | 1 | 0: plain shift registers, 1: latched shift registers |
| cfg_div | input | 2 | Serial clock divisor code (period 4 << code) |
| cfg_dly | input | 5 | Raw clock-to-data delay in system clocks |
| ser_clk | output | 1 | Serial clock; external devices sample on its rising edge |
| ser_data | output | 1 | Serial data |
| ser_latch | output | 1 | Latch strobe for latched chains |
| busy | output | 1 | Transfer in progress |
| rd_word | output | 32 | Readback: bit 31 busy, bits 16:0 captured data |

## Verification
The bench sweeps every divisor code and both modes. For each combination it uses raw delays of 0, 1, just below half the period, exactly half, just above half, and the maximum, so both clamp limits are hit. It predicts every output on every cycle of each transfer. A design with the bit order reversed, or with the data edge off by one clock, would show the wrong bit on some cycle. An unclamped delay would move a data edge into the high phase of the clock, and a wrong decode of the divisor code would stretch or shrink every period. During each transfer the bench also issues a second request and changes the data and all configuration inputs. A design that restarts, recaptures the data or reads the live configuration would then break the predicted stream or the readback. In latched mode, a strobe that is too short or too long, or a busy flag that falls before the strobe ends, would show up in the cycles that follow the 17th period.

// File: rtl/sipo_pkg.sv
// Shared types for the serial shift-register output driver.
// Assumes nothing beyond the state encoding used by the sequencer.
package sipo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2
    } sipo_state_e;
endpackage

// File: rtl/sipo_dly_clamp.sv
// Derives the serial clock period and half period from the divisor code,
// and clamps the raw clock-to-data delay into 1..half period.
// Assumes CNT_W is wide enough to hold the largest period.
module sipo_dly_clamp #(
    parameter int DIV_W = 2,
    parameter int DLY_W = 5,
    parameter int CNT_W = 6
) (
    input  logic [DIV_W-1:0] div_sel,
    input  logic [DLY_W-1:0] dly_raw,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] half,
    output logic [CNT_W-1:0] dly_eff
);
    logic [CNT_W-1:0] raw_ext;

    // Period and half period from the divisor code; delay clamped into range
    always_comb begin
        period  = CNT_W'(4) << div_sel;
        half    = period >> 1;
        raw_ext = CNT_W'(dly_raw);
        if (raw_ext == '0)
            dly_eff = CNT_W'(1);
        else if (raw_ext > half)
            dly_eff = half;
        else
            dly_eff = raw_ext;
    end
endmodule

// File: rtl/sipo_phase_ctr.sv
// Phase counter inside one serial clock period. Counts 0..period-1 while
// run is high and flags the last count. Assumes period >= 2.
module sipo_phase_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] ph,
    output logic             wrap
);
    logic [CNT_W-1:0] ph_q;

    assign ph   = ph_q;
    assign wrap = run && (ph_q == period - CNT_W'(1));

    // Advance the phase, restarting at zero on clear or at period end
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= '0;
        else if (clear)
            ph_q <= '0;
        else if (run)
            ph_q <= wrap ? '0 : ph_q + CNT_W'(1);
    end
endmodule

// File: rtl/sipo_shift_seq.sv
// Transfer sequencer. Captures data and timing at the start, steps through
// DATA_W bit periods, then an optional latch period, and builds the serial
// outputs. Assumes period, half and delay inputs are already validated.
module sipo_shift_seq
    import sipo_pkg::*;
#(
    parameter int DATA_W = 17,
    parameter int CNT_W  = 6,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_mode,
    input  logic [CNT_W-1:0]  period_in,
    input  logic [CNT_W-1:0]  half_in,
    input  logic [CNT_W-1:0]  dly_in,
    input  logic [CNT_W-1:0]  ph,
    input  logic              wrap,
    output logic              ph_clear,
    output logic              ph_run,
    output logic [CNT_W-1:0]  period_q,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_latch,
    output logic              busy,
    output logic [DATA_W-1:0] data_q
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DATA_W - 1);

    sipo_state_e       state_q;
    logic              mode_q;
    logic [CNT_W-1:0]  half_q;
    logic [CNT_W-1:0]  dly_q;
    logic [SLOT_W-1:0] slot_q;
    logic              accept;
    logic              have_bit;
    logic [SLOT_W-1:0] bit_idx;

    assign accept   = start && (state_q == ST_IDLE);
    assign ph_clear = accept;
    assign ph_run   = (state_q != ST_IDLE);

    // State, bit-period index and captured transfer settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            slot_q   <= '0;
            mode_q   <= 1'b0;
            period_q <= CNT_W'(4);
            half_q   <= CNT_W'(2);
            dly_q    <= CNT_W'(1);
            data_q   <= '0;
        end else if (accept) begin
            state_q  <= ST_SHIFT;
            slot_q   <= '0;
            mode_q   <= cfg_mode;
            period_q <= period_in;
            half_q   <= half_in;
            dly_q    <= dly_in;
            data_q   <= wr_data;
        end else if (wrap) begin
            case (state_q)
                ST_SHIFT: begin
                    if (slot_q == LAST_SLOT) begin
                        slot_q  <= '0;
                        state_q <= mode_q ? ST_LATCH : ST_IDLE;
                    end else begin
                        slot_q  <= slot_q + SLOT_W'(1);
                    end
                end
                ST_LATCH: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Pick the bit on the data line: current period after the delay, else previous
    always_comb begin
        have_bit = 1'b0;
        bit_idx  = slot_q;
        if (state_q == ST_SHIFT) begin
            if (ph >= dly_q) begin
                have_bit = 1'b1;
            end else if (slot_q != '0) begin
                have_bit = 1'b1;
                bit_idx  = slot_q - SLOT_W'(1);
            end
        end
    end

    // Serial pin values from state and phase
    always_comb begin
        ser_clk   = (state_q == ST_SHIFT) && (ph >= half_q);
        ser_data  = have_bit && data_q[LAST_SLOT - bit_idx];
        ser_latch = (state_q == ST_LATCH);
        busy      = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/sipo_shift_out.sv
// Top of the serial shift-register output driver. Joins the timing clamp,
// phase counter and sequencer, and forms the readback word.
// Assumes start is a single-cycle request and configuration comes from outside.
module sipo_shift_out #(
    parameter  int DATA_W  = 17,
    parameter  int DIV_W   = 2,
    parameter  int REG_W   = 32,
    localparam int MAX_PER = 4 << ((1 << DIV_W) - 1),
    localparam int CNT_W   = $clog2(MAX_PER) + 1,
    localparam int DLY_W   = CNT_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_mode,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DLY_W-1:0]  cfg_dly,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_latch,
    output logic              busy,
    output logic [REG_W-1:0]  rd_word
);
    localparam int SLOT_W = $clog2(DATA_W + 1);
    localparam int PAD_W  = REG_W - 1 - DATA_W;

    logic [CNT_W-1:0]  period_c;
    logic [CNT_W-1:0]  half_c;
    logic [CNT_W-1:0]  dly_c;
    logic [CNT_W-1:0]  period_q;
    logic [CNT_W-1:0]  ph;
    logic              wrap;
    logic              ph_clear;
    logic              ph_run;
    logic [DATA_W-1:0] data_q;

    sipo_dly_clamp #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) u_clamp (
        .div_sel (cfg_div),
        .dly_raw (cfg_dly),
        .period  (period_c),
        .half    (half_c),
        .dly_eff (dly_c)
    );

    sipo_phase_ctr #(.CNT_W(CNT_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ph_clear),
        .run    (ph_run),
        .period (period_q),
        .ph     (ph),
        .wrap   (wrap)
    );

    sipo_shift_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wr_data   (wr_data),
        .cfg_mode  (cfg_mode),
        .period_in (period_c),
        .half_in   (half_c),
        .dly_in    (dly_c),
        .ph        (ph),
        .wrap      (wrap),
        .ph_clear  (ph_clear),
        .ph_run    (ph_run),
        .period_q  (period_q),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_latch (ser_latch),
        .busy      (busy),
        .data_q    (data_q)
    );

    // Readback word: progress flag on top, captured data at the bottom
    assign rd_word = {busy, {PAD_W{1'b0}}, data_q};
endmodule

// File: rtl/sipo_shift_out_chk.sv
// Property checker for the serial shift-register output driver, bound to
// the top. Watches only the top-level ports.
module sipo_shift_out_chk #(
    parameter int DATA_W  = 17,
    parameter int REG_W   = 32,
    parameter int MAX_PER = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_clk,
    input logic             ser_data,
    input logic             ser_latch,
    input logic             busy,
    input logic [REG_W-1:0] rd_word
);
    logic [7:0] lat_run;

    // Count how long the strobe has been high so far
    always_ff @(posedge clk) begin
        if (!rst_n || !ser_latch)
            lat_run <= '0;
        else if (lat_run != 8'hFF)
            lat_run <= lat_run + 8'd1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_clk && !ser_data && !ser_latch)); // R8
    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data)); // R3
    AST_READBACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_word[DATA_W-1:0])); // R7
    AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ser_latch |-> !ser_clk); // R6
    AST_LATCH_AFTER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_latch) |-> $past(ser_clk)); // R6
    AST_LATCH_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_latch) |-> !busy); // R6
    AST_LATCH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ser_latch |-> (int'(lat_run) < MAX_PER)); // R6
endmodule

bind sipo_shift_out sipo_shift_out_chk #(
    .DATA_W  (DATA_W),
    .REG_W   (REG_W),
    .MAX_PER (MAX_PER)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_latch (ser_latch),
    .busy      (busy),
    .rd_word   (rd_word)
);

// File: tb/sipo_shift_out_test.sv
module sipo_shift_out_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [16:0] wr_data = '0;
    logic        cfg_mode = 1'b0;
    logic [1:0]  cfg_div = 2'd3;
    logic [4:0]  cfg_dly = 5'd1;
    logic        ser_clk, ser_data, ser_latch, busy;
    logic [31:0] rd_word;

    int errors = 0;
    int checks = 0;

    sipo_shift_out uut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_data(wr_data),
        .cfg_mode(cfg_mode), .cfg_div(cfg_div), .cfg_dly(cfg_dly),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_latch(ser_latch),
        .busy(busy), .rd_word(rd_word)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One transfer; every cycle is predicted from n = clocks since the start edge
    task automatic run_xfer(input int div, input int mode, input int raw,
                            input logic [16:0] d, input bit inject);
        int per, half, dly, shift_end, total;
        per  = 4 << div;
        half = per / 2;
        dly  = (raw < 1) ? 1 : ((raw > half) ? half : raw);   // R4 clamp
        shift_end = 17 * per;
        total = shift_end + (mode != 0 ? per : 0);
        @(negedge clk);
        cfg_div  = 2'(div);
        cfg_mode = (mode != 0);
        cfg_dly  = 5'(raw);
        wr_data  = d;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < total + 3; n++) begin
            logic e_clk, e_data, e_lat, e_busy;
            e_clk = 1'b0; e_data = 1'b0; e_lat = 1'b0; e_busy = 1'b0;
            if (n < shift_end) begin
                int slot, ph, idx;
                slot = n / per;
                ph   = n % per;
                idx  = (ph >= dly) ? slot : slot - 1;
                e_clk  = (ph >= half);
                e_data = (idx < 0) ? 1'b0 : d[16 - idx];
                e_busy = 1'b1;
            end else if (n < total) begin
                e_lat  = 1'b1;
                e_busy = 1'b1;
            end
            chk("R2 R9 ser_clk", {31'b0, ser_clk}, {31'b0, e_clk});
            chk("R3 R4 R9 ser_data", {31'b0, ser_data}, {31'b0, e_data});
            chk(mode != 0 ? "R6 ser_latch" : "R5 ser_latch", {31'b0, ser_latch}, {31'b0, e_lat});
            chk("R5 R6 R8 busy", {31'b0, busy}, {31'b0, e_busy});
            chk("R1 R7 rd_word", rd_word, {e_busy, 14'b0, d});
            // R7 R9: second request and new settings mid-transfer
            if (inject && n == 4) begin
                start    = 1'b1;
                wr_data  = ~d;
                cfg_mode = (mode == 0);
                cfg_div  = 2'(div ^ 1);
                cfg_dly  = 5'(31 - raw);
            end
            if (inject && n == 5) start = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk("R8 reset ser_clk", {31'b0, ser_clk}, 32'd0);
        chk("R8 reset ser_data", {31'b0, ser_data}, 32'd0);
        chk("R8 reset ser_latch", {31'b0, ser_latch}, 32'd0);
        chk("R8 reset busy", {31'b0, busy}, 32'd0);
        chk("R8 reset rd_word", rd_word, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int div = 0; div < 4; div++) begin
            for (int mode = 0; mode < 2; mode++) begin
                int half;
                int raws [6];
                half = (4 << div) / 2;
                raws = '{0, 1, half - 1, half, half + 1, 31};
                for (int r = 0; r < 6; r++) begin
                    run_xfer(div, mode, raws[r], 17'h1A5C3, 1'b0);
                    run_xfer(div, mode, raws[r], 17'h10001 ^ 17'(r * 17'h0F3), 1'b1);
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule